// File: doc/BRIEF.md
# Transmit Byte Queue with Per-Write Ready Interrupts

This block is the transmit-side byte queue of a serial port. The CPU writes bytes with a strobe, and the serial shifter takes them from the head with a pop request. The queue reports its fill level and empty/full state. It raises a one-cycle buffer-ready pulse and an overrun pulse, and keeps a sticky overrun flag that only a clear strobe resets.

The queue runs only while its enable bit is set. When a second bit, transparent mode, is also set, buffer-ready pulses no longer follow a fill-level threshold. Instead, a pulse follows every accepted write, every flush, and the moment the mode becomes active. A write into a full queue is not dropped. It replaces the newest entry and reports an overrun. With transparent mode off, the programmable threshold decides when the ready pulse fires.

Top module: `tx_byte_queue`

## Requirements
- R1: After reset the fill level is 0, `q_empty` is 1, `q_full` is 0, and `rdy_irq`, `ovr_irq` and `ovr_flag` are 0.
- R2: Bytes leave in the order written. `head_byte` shows the oldest entry. `fill_lvl` goes from 0 to DEPTH, with `q_full` set at DEPTH and `q_empty` set at 0.
- R3: Transparent mode is active only when `q_en` and `tmode_en` are both 1. In that mode, an accepted write makes `rdy_irq` 1 for exactly the one cycle after the write edge.
- R4: A `flush` empties the queue. With transparent mode active, it also pulses `rdy_irq` in the following cycle. A write in the same cycle as a flush is discarded.
- R5: When transparent mode goes from inactive to active, the queue is emptied and `rdy_irq` pulses once.
- R6: A write to a full queue with no pop in the same cycle gives no `rdy_irq`. It replaces the newest entry, leaves the level at DEPTH, pulses `ovr_irq` for one cycle and sets `ovr_flag`.
- R7: `ovr_flag` stays 1 until `ovr_clr` is applied. A new overrun in the same cycle as the clear wins.
- R8: A write and a pop in the same cycle on a full queue is a normal write. It gives no overrun, pulses `rdy_irq`, and leaves the level at DEPTH.
- R9: A pop on an empty queue has no effect. The level stays 0, and the next write becomes the head.
- R10: With `q_en`=1 and `tmode_en`=0, writes give no `rdy_irq`. Instead, `rdy_irq` pulses after a pop (without a write) that brings the level to `thresh`. In transparent mode `thresh` is ignored.
- R11: While `q_en` is 0 the queue is held empty and writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_en | input | 1 | Queue enable |
| tmode_en | input | 1 | Transparent interrupt mode enable |
| wr_stb | input | 1 | CPU write strobe |
| wr_byte | input | 8 | Byte written by the CPU |
| pop | input | 1 | Head removal request from the shifter |
| flush | input | 1 | Empty the queue |
| ovr_clr | input | 1 | Clear the sticky overrun flag |
| thresh | input | 4 | Fill-level trigger used when transparent mode is off |
| head_byte | output | 8 | Oldest byte in the queue |
| fill_lvl | output | 4 | Number of bytes held (0..DEPTH) |
| q_empty | output | 1 | Level is 0 |
| q_full | output | 1 | Level is DEPTH |
| rdy_irq | output | 1 | One-cycle buffer-ready interrupt |
| ovr_irq | output | 1 | One-cycle overrun interrupt |
| ovr_flag | output | 1 | Sticky overrun flag |

## Verification
Two functions can land on the same edge: a CPU write into a full queue, and a pop by the shifter. Taken alone, the write is an overrun. Together, they are an ordinary accepted write. The bench fills the queue to DEPTH, then asserts `wr_stb` and `pop` in one cycle. It judges the outcome by four things: the ready pulse, the absent overrun pulse, the unchanged level, and the drained byte order, where the new byte must come out last after the remaining originals. A second pairing, a flush alongside a write, is checked to confirm the flush wins.

// File: rtl/txq_pkg.sv
package txq_pkg;
  // wrap-around increment of a ring index
  function automatic int ring_inc(input int p, input int depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

  // wrap-around decrement of a ring index
  function automatic int ring_dec(input int p, input int depth);
    return (p == 0) ? depth - 1 : p - 1;
  endfunction

  // fill level after one cycle of push/pull
  function automatic int lvl_after(input int lvl, input bit push, input bit pull);
    return lvl + (push ? 1 : 0) - (pull ? 1 : 0);
  endfunction
endpackage

// File: rtl/txq_store.sv
module txq_store #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [PW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/txq_ptrs.sv
module txq_ptrs
  import txq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          q_en,
  input  logic          flush,
  input  logic          enter_evt,
  input  logic          wr_stb,
  input  logic          pop,
  output logic          wr_ok,
  output logic          wr_ovr,
  output logic          pop_ok,
  output logic [PW-1:0] wptr,
  output logic [PW-1:0] rptr,
  output logic [PW-1:0] store_addr,
  output logic [CW-1:0] lvl,
  output logic [CW-1:0] lvl_nxt
);
  logic clr_q;
  logic is_full;

  assign clr_q   = !q_en || flush || enter_evt;
  assign is_full = (lvl == CW'(DEPTH));
  assign pop_ok  = !clr_q && pop && (lvl != '0);
  assign wr_ok   = !clr_q && wr_stb && (!is_full || pop_ok);
  assign wr_ovr  = !clr_q && wr_stb && is_full && !pop_ok;
  assign lvl_nxt = clr_q ? '0 : CW'(lvl_after(int'(lvl), wr_ok, pop_ok));
  assign store_addr = wr_ovr ? PW'(ring_dec(int'(wptr), DEPTH)) : wptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      lvl  <= '0;
    end else begin
      lvl <= lvl_nxt;
      if (clr_q) begin
        wptr <= '0;
        rptr <= '0;
      end else begin
        if (wr_ok)  wptr <= PW'(ring_inc(int'(wptr), DEPTH));
        if (pop_ok) rptr <= PW'(ring_inc(int'(rptr), DEPTH));
      end
    end
  end

  // R2: level never exceeds depth
  assert_lvl_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lvl <= CW'(DEPTH));
  // R6: an overrun leaves the level untouched
  assert_ovr_keeps_lvl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ovr |=> lvl == CW'(DEPTH));
  // R9: popping an empty queue leaves the read pointer still
  assert_empty_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && lvl == '0 && !clr_q) |=> $stable(rptr));
  // R11: disabled queue stays empty
  assert_off_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !q_en |=> lvl == '0);
endmodule

// File: rtl/txq_irq.sv
module txq_irq #(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          q_en,
  input  logic          tmode_en,
  input  logic          flush,
  input  logic          wr_ok,
  input  logic          wr_ovr,
  input  logic          pop_ok,
  input  logic          ovr_clr,
  input  logic [CW-1:0] lvl_nxt,
  input  logic [CW-1:0] thresh,
  output logic          enter_evt,
  output logic          rdy_irq,
  output logic          ovr_irq,
  output logic          ovr_flag
);
  logic act, act_q;
  logic thr_hit;
  logic rdy_d;

  assign act       = q_en && tmode_en;
  assign enter_evt = act && !act_q;
  assign thr_hit   = q_en && !tmode_en && pop_ok && !wr_ok && (lvl_nxt == thresh);
  assign rdy_d     = (act && (flush || enter_evt || wr_ok)) || thr_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= 1'b0;
      rdy_irq  <= 1'b0;
      ovr_irq  <= 1'b0;
      ovr_flag <= 1'b0;
    end else begin
      act_q   <= act;
      rdy_irq <= rdy_d;
      ovr_irq <= wr_ovr;
      if (wr_ovr)       ovr_flag <= 1'b1;
      else if (ovr_clr) ovr_flag <= 1'b0;
    end
  end

  // R6: overrun and ready never pulse together
  assert_ovr_no_rdy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ovr |=> !rdy_irq && ovr_irq);
  // R7: flag holds without a clear
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !ovr_clr) |=> ovr_flag);
  // R3: accepted write in transparent mode yields a ready pulse
  assert_write_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && act) |=> rdy_irq);
endmodule

// File: rtl/tx_byte_queue.sv
module tx_byte_queue #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          q_en,
  input  logic          tmode_en,
  input  logic          wr_stb,
  input  logic [W-1:0]  wr_byte,
  input  logic          pop,
  input  logic          flush,
  input  logic          ovr_clr,
  input  logic [CW-1:0] thresh,
  output logic [W-1:0]  head_byte,
  output logic [CW-1:0] fill_lvl,
  output logic          q_empty,
  output logic          q_full,
  output logic          rdy_irq,
  output logic          ovr_irq,
  output logic          ovr_flag
);
  logic          enter_evt, wr_ok, wr_ovr, pop_ok;
  logic [PW-1:0] wptr, rptr, store_addr;
  logic [CW-1:0] lvl, lvl_nxt;

  txq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .q_en(q_en), .flush(flush),
    .enter_evt(enter_evt), .wr_stb(wr_stb), .pop(pop),
    .wr_ok(wr_ok), .wr_ovr(wr_ovr), .pop_ok(pop_ok),
    .wptr(wptr), .rptr(rptr), .store_addr(store_addr),
    .lvl(lvl), .lvl_nxt(lvl_nxt)
  );

  txq_store #(.DEPTH(DEPTH), .W(W)) u_store (
    .clk(clk), .we(wr_ok || wr_ovr), .waddr(store_addr),
    .wdata(wr_byte), .raddr(rptr), .rdata(head_byte)
  );

  txq_irq #(.DEPTH(DEPTH)) u_irq (
    .clk(clk), .rst_n(rst_n), .q_en(q_en), .tmode_en(tmode_en),
    .flush(flush), .wr_ok(wr_ok), .wr_ovr(wr_ovr), .pop_ok(pop_ok),
    .ovr_clr(ovr_clr), .lvl_nxt(lvl_nxt), .thresh(thresh),
    .enter_evt(enter_evt), .rdy_irq(rdy_irq), .ovr_irq(ovr_irq),
    .ovr_flag(ovr_flag)
  );

  assign fill_lvl = lvl;
  assign q_empty  = (lvl == '0);
  assign q_full   = (lvl == CW'(DEPTH));

  // R4: flush leaves the queue empty
  assert_flush_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> q_empty);
  // R8: simultaneous write and pop on full is not an overrun
  assert_full_wr_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (q_full && wr_stb && pop && q_en && !flush && !enter_evt) |=> q_full && !ovr_irq);
endmodule

// File: tb/tx_byte_queue_tb.sv
module tx_byte_queue_tb;
  localparam int DEPTH = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       q_en = 1'b0, tmode_en = 1'b0, wr_stb = 1'b0, pop = 1'b0;
  logic       flush = 1'b0, ovr_clr = 1'b0;
  logic [7:0] wr_byte = '0;
  logic [3:0] thresh = '0;
  logic [7:0] head_byte;
  logic [3:0] fill_lvl;
  logic       q_empty, q_full, rdy_irq, ovr_irq, ovr_flag;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tx_byte_queue #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .q_en(q_en), .tmode_en(tmode_en),
    .wr_stb(wr_stb), .wr_byte(wr_byte), .pop(pop), .flush(flush),
    .ovr_clr(ovr_clr), .thresh(thresh), .head_byte(head_byte),
    .fill_lvl(fill_lvl), .q_empty(q_empty), .q_full(q_full),
    .rdy_irq(rdy_irq), .ovr_irq(ovr_irq), .ovr_flag(ovr_flag)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // drive one cycle of stimulus, return after the edge at the next negedge
  task automatic step(input bit w, input logic [7:0] d, input bit p,
                      input bit f, input bit c);
    wr_stb = w; wr_byte = d; pop = p; flush = f; ovr_clr = c;
    @(negedge clk);
    wr_stb = 0; pop = 0; flush = 0; ovr_clr = 0;
  endtask

  task automatic t_reset();
    chk("R1", "level", fill_lvl, 0);
    chk("R1", "empty", q_empty, 1);
    chk("R1", "full", q_full, 0);
    chk("R1", "irqs", {rdy_irq, ovr_irq, ovr_flag}, 0);
  endtask

  task automatic t_enter();
    q_en = 1; tmode_en = 1;
    @(negedge clk);
    chk("R5", "enter pulse", rdy_irq, 1);
    chk("R5", "enter level", fill_lvl, 0);
    @(negedge clk);
    chk("R5", "pulse one cycle", rdy_irq, 0);
  endtask

  task automatic t_order();
    for (int i = 0; i < 3; i++) begin
      step(1, 8'hA0 + 8'(i), 0, 0, 0);
      chk("R3", "write pulse", rdy_irq, 1);
      chk("R2", "level up", fill_lvl, i + 1);
    end
    @(negedge clk);
    chk("R3", "pulse drops", rdy_irq, 0);
    for (int i = 0; i < 3; i++) begin
      chk("R2", "head order", head_byte, 8'hA0 + i);
      step(0, 0, 1, 0, 0);
    end
    chk("R2", "empty after drain", q_empty, 1);
  endtask

  task automatic t_overrun();
    for (int i = 0; i < DEPTH; i++) step(1, 8'h10 + 8'(i), 0, 0, 0);
    chk("R2", "full flag", q_full, 1);
    step(1, 8'hEE, 0, 0, 0);
    chk("R6", "no ready", rdy_irq, 0);
    chk("R6", "ovr pulse", ovr_irq, 1);
    chk("R6", "flag set", ovr_flag, 1);
    chk("R6", "level kept", fill_lvl, DEPTH);
    for (int i = 0; i < 4; i++) @(negedge clk);
    chk("R6", "ovr pulse ends", ovr_irq, 0);
    chk("R7", "flag sticky", ovr_flag, 1);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R6", "drain order", head_byte, (i == DEPTH - 1) ? 8'hEE : 8'h10 + i);
      step(0, 0, 1, 0, 0);
    end
    step(0, 0, 0, 0, 1);
    chk("R7", "flag cleared", ovr_flag, 0);
  endtask

  task automatic t_full_wr_pop();
    for (int i = 0; i < DEPTH; i++) step(1, 8'hB0 + 8'(i), 0, 0, 0);
    step(1, 8'hC0, 1, 0, 0);
    chk("R8", "level stays", fill_lvl, DEPTH);
    chk("R8", "ready pulse", rdy_irq, 1);
    chk("R8", "no overrun", ovr_irq, 0);
    chk("R8", "no flag", ovr_flag, 0);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R8", "drain order", head_byte, (i == DEPTH - 1) ? 8'hC0 : 8'hB1 + i);
      step(0, 0, 1, 0, 0);
    end
  endtask

  task automatic t_flush();
    step(1, 8'h55, 0, 0, 0);
    step(1, 8'h66, 0, 0, 0);
    step(1, 8'h77, 0, 1, 0);
    chk("R4", "flush level", fill_lvl, 0);
    chk("R4", "flush pulse", rdy_irq, 1);
    @(negedge clk);
    chk("R4", "write dropped", q_empty, 1);
  endtask

  task automatic t_empty_pop();
    step(0, 0, 1, 0, 0);
    chk("R9", "level stays", fill_lvl, 0);
    step(1, 8'hD0, 0, 0, 0);
    chk("R9", "head after", head_byte, 8'hD0);
    chk("R9", "level one", fill_lvl, 1);
    step(0, 0, 1, 0, 0);
  endtask

  task automatic t_thresh();
    tmode_en = 0; thresh = 4'd2;
    for (int i = 0; i < 4; i++) begin
      step(1, 8'h30 + 8'(i), 0, 0, 0);
      chk("R10", "no write pulse", rdy_irq, 0);
    end
    step(0, 0, 1, 0, 0);
    chk("R10", "level 3 no pulse", rdy_irq, 0);
    step(0, 0, 1, 0, 0);
    chk("R10", "level 2 pulse", rdy_irq, 1);
    step(0, 0, 1, 0, 0);
    chk("R10", "level 1 no pulse", rdy_irq, 0);
    tmode_en = 1;
    @(negedge clk);
    chk("R5", "reenter empties", fill_lvl, 0);
    chk("R5", "reenter pulse", rdy_irq, 1);
    for (int i = 0; i < 3; i++) step(1, 8'h40, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    chk("R10", "thresh ignored", rdy_irq, 0);
    chk("R10", "level 2", fill_lvl, 2);
  endtask

  task automatic t_disabled();
    q_en = 0;
    @(negedge clk);
    chk("R11", "held empty", fill_lvl, 0);
    step(1, 8'h99, 0, 0, 0);
    chk("R11", "write ignored", q_empty, 1);
    chk("R3", "no pulse when off", rdy_irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_enter();
    t_order();
    t_overrun();
    t_full_wr_pop();
    t_flush();
    t_empty_pop();
    t_thresh();
    t_disabled();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule